// File: doc/BRIEF.md
# Microcoded Accumulator Core

This block is a small accumulator processor. Each machine instruction is carried out by a short microprogram held in an internal control store. The datapath has these parts:

- a 512-word by 32-bit memory, addressed by word;
- an accumulator;
- a 16-bit program counter;
- a memory address register and a memory data register;
- a temporary register and an instruction register;
- a micro-program counter and a micro-instruction register;
- an ALU that can add, subtract and increment.

Every micro-instruction performs exactly one register move or one memory action. Each micro-instruction takes two clocks. The first clock loads the micro-instruction register from the control store. The second clock executes it.

The program counter is never incremented in place. Each routine that falls through to the next instruction first parks the accumulator in the temporary register. It then forms PC+1 in the accumulator, copies that value to the PC, and restores the accumulator. There is no direct path from the memory data register to the memory address register. An effective address therefore always passes through the temporary register. Tests fill memory through a preload port while reset is held. They observe the core only through the accumulator and PC outputs.

Top module: `uacc_core`

## Requirements
- R1: While reset is held, the accumulator, PC and micro-PC are zero. The outputs `acc_o` and `pc_o` read 0.
- R2: An instruction word holds its opcode in bits 31:16 and its operand in bits 15:0. The opcodes are, in decimal: ADD=10, SUB=20, LDA=30, STR=40, BRH=50, CBR=60, LDI=70. After the fetch microprogram, control dispatches to the micro-address equal to the opcode.
- R3: ADD sets ACC to ACC + mem[operand], modulo 2^32. The PC then advances by 1.
- R4: SUB sets ACC to ACC - mem[operand], modulo 2^32. The PC then advances by 1.
- R5: LDA sets ACC to mem[operand]. The PC then advances by 1.
- R6: STR writes ACC to mem[operand] and leaves ACC unchanged. The PC then advances by 1.
- R7: LDI sets ACC to the operand, zero-extended to 32 bits. It makes no memory access, and the PC then advances by 1.
- R8: BRH sets the PC to the operand and leaves ACC unchanged.
- R9: CBR sets the PC to the operand when ACC is zero. Otherwise the PC advances by 1. In both cases ACC keeps its value.
- R10: Only the low 9 bits of the address register select a memory word.
- R11: While `pre_we_i` is high, `pre_data_i` is written to the memory word at `pre_addr_i`.
- R12: Every routine ends by jumping the micro-PC to 0, which begins the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pre_we_i | input | 1 | Preload write strobe |
| pre_addr_i | input | 9 | Preload word address |
| pre_data_i | input | 32 | Preload data |
| acc_o | output | 32 | Accumulator view |
| pc_o | output | 16 | Program counter view |

## Verification
Each opcode is tried on its own, placed after an LDI that sets a known starting accumulator, and followed by a self-branch that freezes the final state. The test values are chosen to separate the cases:

- ADD operands that carry out of 32 bits, and a SUB that borrows, show whether the arithmetic wraps.
- CBR is run with a zero and with a nonzero accumulator. This separates the taken path from the fall-through path, and shows whether ACC survives being parked during the PC increment.
- A store is followed by a load from the same address, which shows that STR really wrote memory.
- An operand with bits above bit 8 set shows whether the upper address bits are ignored.

// File: rtl/uacc_pkg.sv
package uacc_pkg;
   localparam int UPC_W = 7;

   typedef enum logic [4:0] {
      UO_NOP, UO_SAR_PC, UO_READ, UO_IR_SDR, UO_SDR_OPND, UO_DISPATCH,
      UO_TMP_ACC, UO_ACC_PCINC, UO_PC_ACC, UO_ACC_TMP, UO_TMP_SDR,
      UO_SAR_TMP, UO_ADD, UO_SUB, UO_ACC_SDR, UO_SDR_ACC, UO_WRITE,
      UO_PC_SDR, UO_SKIP, UO_JUMP
   } uop_e;

   typedef struct packed {
      uop_e             op;
      logic [UPC_W-1:0] tgt;
   } uinstr_t;

   typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_INC} alu_sel_e;
endpackage

// File: rtl/uacc_ustore.sv
module uacc_ustore
   import uacc_pkg::*;
(
   input  logic [UPC_W-1:0] addr_i,
   output uinstr_t          word_o
);
   always_comb begin
      word_o = '{op: UO_JUMP, tgt: '0};
      case (addr_i)
         7'd0:                                   word_o.op = UO_SAR_PC;
         7'd1, 7'd16, 7'd26, 7'd36:              word_o.op = UO_READ;
         7'd2:                                   word_o.op = UO_IR_SDR;
         7'd3:                                   word_o.op = UO_SDR_OPND;
         7'd4:                                   word_o.op = UO_DISPATCH;
         7'd10, 7'd20, 7'd30, 7'd40, 7'd64, 7'd70: word_o.op = UO_TMP_ACC;
         7'd11, 7'd21, 7'd31, 7'd41, 7'd65, 7'd71: word_o.op = UO_ACC_PCINC;
         7'd12, 7'd22, 7'd32, 7'd42, 7'd66, 7'd72: word_o.op = UO_PC_ACC;
         7'd13, 7'd23, 7'd33, 7'd43, 7'd67, 7'd73: word_o.op = UO_ACC_TMP;
         7'd14, 7'd24, 7'd34, 7'd44, 7'd17, 7'd27: word_o.op = UO_TMP_SDR;
         7'd15, 7'd25, 7'd35, 7'd45:             word_o.op = UO_SAR_TMP;
         7'd18:                                  word_o.op = UO_ADD;
         7'd28:                                  word_o.op = UO_SUB;
         7'd37, 7'd74:                           word_o.op = UO_ACC_SDR;
         7'd46:                                  word_o.op = UO_SDR_ACC;
         7'd47:                                  word_o.op = UO_WRITE;
         7'd50, 7'd62:                           word_o.op = UO_PC_SDR;
         7'd60:                                  word_o.op = UO_SKIP;
         7'd61:                                  word_o = '{op: UO_JUMP, tgt: 7'd64};
         default:                                word_o = '{op: UO_JUMP, tgt: '0};
      endcase
   end
endmodule

// File: rtl/uacc_alu.sv
module uacc_alu
   import uacc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  alu_sel_e          sel_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] y_o
);
   always_comb begin
      case (sel_i)
         ALU_SUB: y_o = a_i - b_i;
         ALU_INC: y_o = a_i + {{(DATA_W-1){1'b0}}, 1'b1};
         default: y_o = a_i + b_i;
      endcase
   end
endmodule

// File: rtl/uacc_mem.sv
module uacc_mem #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 9
) (
   input  logic              clk_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store_q [DEPTH];

   always_ff @(posedge clk_i) begin
      if (we_i) store_q[waddr_i] <= wdata_i;
   end

   assign rdata_o = store_q[raddr_i];

   // R11: a write is visible on the read side at the next cycle
   a_r11_write_visible: assert property (@(posedge clk_i)
      (we_i && raddr_i == waddr_i) |=> (rdata_o == $past(wdata_i) || $past(raddr_i) != raddr_i || we_i));
endmodule

// File: rtl/uacc_core.sv
module uacc_core
   import uacc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int HALF_W = 16,
   parameter int ADDR_W = 9
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              pre_we_i,
   input  logic [ADDR_W-1:0] pre_addr_i,
   input  logic [DATA_W-1:0] pre_data_i,
   output logic [DATA_W-1:0] acc_o,
   output logic [HALF_W-1:0] pc_o
);
   localparam logic [HALF_W-1:0] HALF_ZERO = '0;

   generate
      if (DATA_W != 2 * HALF_W) begin : g_bad_split
         $error("DATA_W must be twice HALF_W");
      end
      if (ADDR_W > HALF_W || ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must lie in 1..HALF_W");
      end
      if (HALF_W < UPC_W) begin : g_bad_opc
         $error("opcode field narrower than micro-PC");
      end
   endgenerate

   logic [DATA_W-1:0] acc_q, sdr_q, tmp_q, ir_q;
   logic [HALF_W-1:0] pc_q, sar_q;
   logic [UPC_W-1:0]  upc_q;
   uinstr_t           mir_q;
   logic              exec_q;

   uinstr_t           rom_word;
   alu_sel_e          alu_sel;
   logic [DATA_W-1:0] alu_a, alu_b, alu_y;
   logic [DATA_W-1:0] mem_rd;
   logic              core_we;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_waddr;
   logic [DATA_W-1:0] mem_wdata;

   uacc_ustore u_store (.addr_i(upc_q), .word_o(rom_word));

   always_comb begin
      alu_sel = ALU_ADD;
      alu_a   = acc_q;
      alu_b   = tmp_q;
      case (mir_q.op)
         UO_SUB:       alu_sel = ALU_SUB;
         UO_ACC_PCINC: begin
            alu_sel = ALU_INC;
            alu_a   = {HALF_ZERO, pc_q};
         end
         default:      alu_sel = ALU_ADD;
      endcase
   end

   uacc_alu #(.DATA_W(DATA_W)) u_alu (
      .sel_i(alu_sel), .a_i(alu_a), .b_i(alu_b), .y_o(alu_y)
   );

   assign core_we   = exec_q && (mir_q.op == UO_WRITE);
   assign mem_we    = pre_we_i || core_we;
   assign mem_waddr = pre_we_i ? pre_addr_i : sar_q[ADDR_W-1:0];
   assign mem_wdata = pre_we_i ? pre_data_i : sdr_q;

   uacc_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
      .clk_i(clk_i), .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
      .raddr_i(sar_q[ADDR_W-1:0]), .rdata_o(mem_rd)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         acc_q  <= '0;
         pc_q   <= '0;
         sar_q  <= '0;
         sdr_q  <= '0;
         tmp_q  <= '0;
         ir_q   <= '0;
         upc_q  <= '0;
         mir_q  <= '{op: UO_NOP, tgt: '0};
         exec_q <= 1'b0;
      end else if (!exec_q) begin
         mir_q  <= rom_word;
         exec_q <= 1'b1;
      end else begin
         exec_q <= 1'b0;
         upc_q  <= upc_q + 1'b1;
         case (mir_q.op)
            UO_SAR_PC:    sar_q <= pc_q;
            UO_READ:      sdr_q <= mem_rd;
            UO_IR_SDR:    ir_q  <= sdr_q;
            UO_SDR_OPND:  sdr_q <= {HALF_ZERO, ir_q[HALF_W-1:0]};
            UO_DISPATCH:  upc_q <= ir_q[HALF_W +: UPC_W];
            UO_TMP_ACC:   tmp_q <= acc_q;
            UO_ACC_PCINC: acc_q <= alu_y;
            UO_PC_ACC:    pc_q  <= acc_q[HALF_W-1:0];
            UO_ACC_TMP:   acc_q <= tmp_q;
            UO_TMP_SDR:   tmp_q <= sdr_q;
            UO_SAR_TMP:   sar_q <= tmp_q[HALF_W-1:0];
            UO_ADD,
            UO_SUB:       acc_q <= alu_y;
            UO_ACC_SDR:   acc_q <= sdr_q;
            UO_SDR_ACC:   sdr_q <= acc_q;
            UO_PC_SDR:    pc_q  <= sdr_q[HALF_W-1:0];
            UO_SKIP:      upc_q <= upc_q + ((acc_q == '0) ? 7'd2 : 7'd1);
            UO_JUMP:      upc_q <= mir_q.tgt;
            default:      ;
         endcase
      end
   end

   assign acc_o = acc_q;
   assign pc_o  = pc_q;

   // R1: the cycle after reset is held, the visible state is clear
   a_r1_reset_clear: assert property (@(posedge clk_i)
      $past(rst_i) |-> (acc_q == '0 && pc_q == '0 && upc_q == '0));
   // R2: dispatch lands on the opcode's micro-address
   a_r2_dispatch: assert property (@(posedge clk_i) disable iff (rst_i)
      (exec_q && mir_q.op == UO_DISPATCH) |=> upc_q == $past(ir_q[HALF_W +: UPC_W]));
   // R3: add result equals the sum of the old operands
   a_r3_add_sum: assert property (@(posedge clk_i) disable iff (rst_i)
      (exec_q && mir_q.op == UO_ADD) |=> acc_q == $past(acc_q) + $past(tmp_q));
   // R8: a branch micro-op takes the operand from the data register
   a_r8_branch_pc: assert property (@(posedge clk_i) disable iff (rst_i)
      (exec_q && mir_q.op == UO_PC_SDR) |=> pc_q == $past(sdr_q[HALF_W-1:0]));
   // R9: zero accumulator skips one micro-address
   a_r9_skip_zero: assert property (@(posedge clk_i) disable iff (rst_i)
      (exec_q && mir_q.op == UO_SKIP && acc_q == '0) |=> upc_q == $past(upc_q) + 7'd2);
   // R12: the return micro-op lands on its target
   a_r12_return: assert property (@(posedge clk_i) disable iff (rst_i)
      (exec_q && mir_q.op == UO_JUMP) |=> upc_q == $past(mir_q.tgt));
endmodule

// File: tb/uacc_core_test.sv
module uacc_core_test;
   logic        clk = 1'b0;
   logic        rst;
   logic        pre_we;
   logic [8:0]  pre_addr;
   logic [31:0] pre_data;
   logic [31:0] acc;
   logic [15:0] pc;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   uacc_core uut (
      .clk_i(clk), .rst_i(rst), .pre_we_i(pre_we), .pre_addr_i(pre_addr),
      .pre_data_i(pre_data), .acc_o(acc), .pc_o(pc)
   );

   localparam logic [15:0] OP_ADD = 16'd10, OP_SUB = 16'd20, OP_LDA = 16'd30,
                           OP_STR = 16'd40, OP_BRH = 16'd50, OP_CBR = 16'd60,
                           OP_LDI = 16'd70;

   typedef struct packed {
      logic [23:0] tag;
      logic [15:0] init;
      logic [15:0] opc;
      logic [15:0] opnd;
      logic [31:0] data;
      logic [31:0] exp_acc;
      logic [15:0] exp_pc;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{"R3", 16'd5, OP_ADD, 16'd100, 32'd7,          32'd12,         16'd2},
      '{"R3", 16'd1, OP_ADD, 16'd100, 32'hFFFF_FFFF,  32'd0,          16'd2},
      '{"R4", 16'd9, OP_SUB, 16'd100, 32'd4,          32'd5,          16'd2},
      '{"R4", 16'd5, OP_SUB, 16'd100, 32'd7,          32'hFFFF_FFFE,  16'd2},
      '{"R5", 16'd3, OP_LDA, 16'd100, 32'hDEAD_BEEF,  32'hDEAD_BEEF,  16'd2},
      '{"R7", 16'd3, OP_LDI, 16'hABCD, 32'd0,         32'h0000_ABCD,  16'd2},
      '{"R8", 16'd3, OP_BRH, 16'd20,  32'd0,          32'd3,          16'd20},
      '{"R9", 16'd0, OP_CBR, 16'd20,  32'd0,          32'd0,          16'd20},
      '{"R9", 16'd4, OP_CBR, 16'd20,  32'd0,          32'd4,          16'd2},
      '{"R6", 16'd6, OP_STR, 16'd100, 32'd0,          32'd6,          16'd2}
   };

   function automatic logic [31:0] ins(input logic [15:0] o, input logic [15:0] a);
      return {o, a};
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic poke(input int a, input logic [31:0] d);
      @(negedge clk);
      pre_we   = 1'b1;
      pre_addr = a[8:0];
      pre_data = d;
      @(posedge clk);
      #1 pre_we = 1'b0;
   endtask

   task automatic run(input int cycles);
      @(negedge clk);
      rst = 1'b0;
      repeat (cycles) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      rst = 1'b1; pre_we = 1'b0; pre_addr = '0; pre_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: held reset gives a clear accumulator and PC
      check("R1 acc", acc, 32'd0);
      check("R1 pc", {16'd0, pc}, 32'd0);

      // R2 opcode field in bits 31:16; R11 preload while reset
      for (int i = 0; i < NV; i++) begin
         rst = 1'b1;
         poke(0,   ins(OP_LDI, VECS[i].init));
         poke(1,   ins(VECS[i].opc, VECS[i].opnd));
         poke(2,   ins(OP_BRH, 16'd2));
         poke(20,  ins(OP_BRH, 16'd20));
         poke(100, VECS[i].data);
         run(400);
         check({string'(VECS[i].tag), " acc"}, acc, VECS[i].exp_acc);
         check({string'(VECS[i].tag), " pc"}, {16'd0, pc}, {16'd0, VECS[i].exp_pc});
      end

      // R6: a stored value is read back by LDA; R12 chains several routines
      rst = 1'b1;
      poke(50, 32'd0);
      poke(0, ins(OP_LDI, 16'd7));
      poke(1, ins(OP_STR, 16'd50));
      poke(2, ins(OP_LDI, 16'd0));
      poke(3, ins(OP_LDA, 16'd50));
      poke(4, ins(OP_BRH, 16'd4));
      run(600);
      check("R6 readback", acc, 32'd7);
      check("R12 pc", {16'd0, pc}, 32'd4);

      // R10: operand 0x0264 selects word 100 through its low 9 bits
      rst = 1'b1;
      poke(0, ins(OP_LDI, 16'd1));
      poke(1, ins(OP_LDA, 16'h0264));
      poke(2, ins(OP_BRH, 16'd2));
      poke(100, 32'h0000_0055);
      run(400);
      check("R10 wrap", acc, 32'h0000_0055);

      // R12: a decrement loop exercises repeated fetch after each routine
      rst = 1'b1;
      poke(0, ins(OP_LDI, 16'd3));
      poke(1, ins(OP_SUB, 16'd99));
      poke(2, ins(OP_CBR, 16'd4));
      poke(3, ins(OP_BRH, 16'd1));
      poke(4, ins(OP_BRH, 16'd4));
      poke(99, 32'd1);
      run(2000);
      check("R12 loop acc", acc, 32'd0);
      check("R12 loop pc", {16'd0, pc}, 32'd4);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule